// File: doc/BRIEF.md
# Virtual CPU Interrupt Interface

This block is the register window that a guest sees for one virtual CPU of a virtualised interrupt controller. A hypervisor places the interrupts meant for the guest into a small set of list entries, four by default. The guest works with them through a simple 32-bit word-addressed register port. The guest reads an acknowledge register to take the most urgent pending entry, which marks that entry active. Later it writes the same interrupt identity to an end-of-interrupt register, which frees the entry again.

The hypervisor side loads whole list entries through a dedicated load port. All list entries are exported as one flat vector, so the maintenance logic next to the block can watch their states. The guest can also read and write a control word, whose bit 0 enables the virtual interface, and can write a virtual priority mask. A read-only identification word is also provided. Any access to an offset that is not mapped reads as zero, changes nothing, and raises an error flag in the same cycle.

Word offsets used by the guest port: 0 control (read/write), 1 priority mask (write), 2 acknowledge (read), 3 end-of-interrupt (write), 4 identification (read). List entry layout: virtual ID [9:0], source CPU [12:10], EOI request [19], priority [27:23], state [29:28] (0 invalid, 1 pending, 2 active, 3 pending and active), group [30], HW [31].

Top module: `virq_cpu_port`

## Requirements
- R1: A guest read of offset 2 returns 1023 when control bit 0 is clear or when no list entry has state 1 (pending).
- R2: Otherwise the read of offset 2 returns the selected entry's virtual ID in bits 9:0 and its source CPU in bits 12:10, with bits 31:13 zero. The selected entry is the pending entry with the lowest priority value (bits 27:23); on equal priority, the lowest index wins.
- R3: A successful acknowledge sets the selected entry's state field (bits 29:28) to 2 (active). The change is visible on the exported list state after the clock edge that ends the read.
- R4: A guest write to offset 3 takes an ID from bits 9:0 and a CPU from bits 12:10. It sets to 0 (invalid) the state of the lowest-index entry whose state is not 0 and whose ID and CPU both match.
- R5: An end-of-interrupt write that matches no entry changes no list entry.
- R6: A write to offset 1 stores bits 4:0 as the virtual priority mask on `vPriMask`. The control word at offset 0 is written and read back as a whole 32-bit word.
- R7: A read of offset 4 returns the `ID_VALUE` parameter.
- R8: A load on the hypervisor port replaces the whole entry at `lrLoadIdx`. Entry i appears at bits 32*i+31 to 32*i of `lrState`. After reset, every entry, the control word and the priority mask are zero.
- R9: Reads of offsets 1, 3, 5, 6, 7 and writes to offsets 2, 4, 5, 6, 7 read as zero, change no state, and drive `accessErr` high in the same cycle. Mapped accesses leave it low.
- R10: When a hypervisor load and a guest acknowledge target the same entry in the same cycle, the loaded word wins. The read still returns the entry as it was before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guestRdEn | input | 1 | Guest read strobe |
| guestWrEn | input | 1 | Guest write strobe |
| guestAddr | input | 3 | Guest word offset |
| guestWrData | input | 32 | Guest write data |
| guestRdData | output | 32 | Guest read data, valid in the cycle of the read |
| accessErr | output | 1 | Access to an unmapped offset in this cycle |
| lrLoadEn | input | 1 | Hypervisor list entry load strobe |
| lrLoadIdx | input | 2 | Index of the entry to load |
| lrLoadData | input | 32 | Word to load into the entry |
| lrState | output | 128 | All list entries, entry i at bits 32*i+31:32*i |
| vPriMask | output | 5 | Virtual priority mask |

## Verification
Some properties are checked on every cycle. An acknowledge with the interface disabled, or with nothing pending, must return 1023. A successful acknowledge lowers the pending count by exactly one. An end-of-interrupt write never raises the pending count. An erroring access leaves the entries and the control word untouched. Other behaviour can only be shown by the bench scenarios. These cover which entry wins under every combination of four priority values, including ties, and the exact word returned. They also cover which entry an end-of-interrupt frees when IDs or CPUs only partly match, and the order of precedence when a load collides with an acknowledge.

// File: rtl/virq_cpu_port_pkg.sv
package virq_cpu_port_pkg;

  // guest word offsets
  localparam int OFS_CTRL  = 0;
  localparam int OFS_PMASK = 1;
  localparam int OFS_ACK   = 2;
  localparam int OFS_EOI   = 3;
  localparam int OFS_ID    = 4;

  // list entry field positions
  localparam int VID_LSB   = 0;
  localparam int VID_W     = 10;
  localparam int CPU_LSB   = 10;
  localparam int CPU_W     = 3;
  localparam int PRIO_LSB  = 23;
  localparam int PRIO_W    = 5;
  localparam int STATE_LSB = 28;

  localparam logic [31:0] NO_IRQ = 32'd1023;
  localparam int SEL_W = 4;   // index field wide enough for up to 16 entries

  typedef enum logic [1:0] {
    ST_INVALID  = 2'd0,
    ST_PEND     = 2'd1,
    ST_ACTIVE   = 2'd2,
    ST_PEND_ACT = 2'd3
  } entryState_e;

  typedef struct packed {
    logic             ctrlWr;
    logic             maskWr;
    logic             ackTake;
    logic [SEL_W-1:0] ackIdx;
    logic             eoiHit;
    logic [SEL_W-1:0] eoiIdx;
  } strobe_t;

endpackage

// File: rtl/virq_cpu_port_ctrl.sv
module virq_cpu_port_ctrl
  import virq_cpu_port_pkg::*;
#(
  parameter int          NUM_LR   = 4,
  parameter int          ADDR_W   = 3,
  parameter logic [31:0] ID_VALUE = 32'h0000_5A3B
) (
  input  logic                 guestRdEn,
  input  logic                 guestWrEn,
  input  logic [ADDR_W-1:0]    guestAddr,
  input  logic [31:0]          guestWrData,
  input  logic [NUM_LR*32-1:0] lrFlat,
  input  logic [31:0]          ctrlWord,
  output strobe_t              strobe,
  output logic [31:0]          guestRdData,
  output logic                 accessErr
);

  logic             bestFound;
  logic [SEL_W-1:0] bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic             matchFound;
  logic [SEL_W-1:0] matchIdx;
  logic             rdMapped;
  logic             wrMapped;
  logic             ackValid;
  logic [31:0]      bestWord;

  // pick the pending entry with lowest priority value, lowest index on ties
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestPrio  = '1;
    bestWord  = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (lrFlat[i*32+STATE_LSB +: 2] == ST_PEND &&
          (!bestFound || lrFlat[i*32+PRIO_LSB +: PRIO_W] < bestPrio)) begin
        bestFound = 1'b1;
        bestIdx   = SEL_W'(i);
        bestPrio  = lrFlat[i*32+PRIO_LSB +: PRIO_W];
        bestWord  = lrFlat[i*32 +: 32];
      end
    end
  end

  // find the lowest-index live entry matching ID and CPU
  always_comb begin
    matchFound = 1'b0;
    matchIdx   = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (!matchFound &&
          lrFlat[i*32+STATE_LSB +: 2] != ST_INVALID &&
          lrFlat[i*32+VID_LSB +: VID_W] == guestWrData[VID_LSB +: VID_W] &&
          lrFlat[i*32+CPU_LSB +: CPU_W] == guestWrData[CPU_LSB +: CPU_W]) begin
        matchFound = 1'b1;
        matchIdx   = SEL_W'(i);
      end
    end
  end

  assign rdMapped = (guestAddr == ADDR_W'(OFS_CTRL)) || (guestAddr == ADDR_W'(OFS_ACK)) ||
                    (guestAddr == ADDR_W'(OFS_ID));
  assign wrMapped = (guestAddr == ADDR_W'(OFS_CTRL)) || (guestAddr == ADDR_W'(OFS_PMASK)) ||
                    (guestAddr == ADDR_W'(OFS_EOI));
  assign ackValid = bestFound && ctrlWord[0];
  assign accessErr = (guestRdEn && !rdMapped) || (guestWrEn && !wrMapped);

  always_comb begin
    guestRdData = '0;
    if (guestRdEn) begin
      if (guestAddr == ADDR_W'(OFS_CTRL))
        guestRdData = ctrlWord;
      else if (guestAddr == ADDR_W'(OFS_ACK))
        guestRdData = ackValid
                    ? {19'd0, bestWord[CPU_LSB +: CPU_W], bestWord[VID_LSB +: VID_W]}
                    : NO_IRQ;
      else if (guestAddr == ADDR_W'(OFS_ID))
        guestRdData = ID_VALUE;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.ctrlWr  = guestWrEn && (guestAddr == ADDR_W'(OFS_CTRL));
    strobe.maskWr  = guestWrEn && (guestAddr == ADDR_W'(OFS_PMASK));
    strobe.ackTake = guestRdEn && (guestAddr == ADDR_W'(OFS_ACK)) && ackValid;
    strobe.ackIdx  = bestIdx;
    strobe.eoiHit  = guestWrEn && (guestAddr == ADDR_W'(OFS_EOI)) && matchFound;
    strobe.eoiIdx  = matchIdx;
  end

endmodule

// File: rtl/virq_cpu_port_dp.sv
module virq_cpu_port_dp
  import virq_cpu_port_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strobe,
  input  logic [31:0]          guestWrData,
  input  logic                 lrLoadEn,
  input  logic [IDX_W-1:0]     lrLoadIdx,
  input  logic [31:0]          lrLoadData,
  output logic [NUM_LR*32-1:0] lrFlat,
  output logic [31:0]          ctrlWord,
  output logic [PRIO_W-1:0]    vPriMask
);

  for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
    logic [31:0] entry;
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry <= '0;
      else if (lrLoadEn && lrLoadIdx == IDX_W'(i))
        entry <= lrLoadData;
      else if (strobe.ackTake && strobe.ackIdx == SEL_W'(i))
        entry[STATE_LSB +: 2] <= ST_ACTIVE;
      else if (strobe.eoiHit && strobe.eoiIdx == SEL_W'(i))
        entry[STATE_LSB +: 2] <= ST_INVALID;
    end
    assign lrFlat[i*32 +: 32] = entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlWord <= '0;
      vPriMask <= '0;
    end else begin
      if (strobe.ctrlWr) ctrlWord <= guestWrData;
      if (strobe.maskWr) vPriMask <= guestWrData[PRIO_W-1:0];
    end
  end

endmodule

// File: rtl/virq_cpu_port.sv
module virq_cpu_port
  import virq_cpu_port_pkg::*;
#(
  parameter int          NUM_LR   = 4,
  parameter int          ADDR_W   = 3,
  parameter logic [31:0] ID_VALUE = 32'h0000_5A3B,
  localparam int         IDX_W    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 guestRdEn,
  input  logic                 guestWrEn,
  input  logic [ADDR_W-1:0]    guestAddr,
  input  logic [31:0]          guestWrData,
  output logic [31:0]          guestRdData,
  output logic                 accessErr,
  input  logic                 lrLoadEn,
  input  logic [IDX_W-1:0]     lrLoadIdx,
  input  logic [31:0]          lrLoadData,
  output logic [NUM_LR*32-1:0] lrState,
  output logic [PRIO_W-1:0]    vPriMask
);

  strobe_t     strobe;
  logic [31:0] ctrlWord;

  virq_cpu_port_ctrl #(.NUM_LR(NUM_LR), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_ctrl (
    .guestRdEn  (guestRdEn),
    .guestWrEn  (guestWrEn),
    .guestAddr  (guestAddr),
    .guestWrData(guestWrData),
    .lrFlat     (lrState),
    .ctrlWord   (ctrlWord),
    .strobe     (strobe),
    .guestRdData(guestRdData),
    .accessErr  (accessErr)
  );

  virq_cpu_port_dp #(.NUM_LR(NUM_LR)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .guestWrData(guestWrData),
    .lrLoadEn   (lrLoadEn),
    .lrLoadIdx  (lrLoadIdx),
    .lrLoadData (lrLoadData),
    .lrFlat     (lrState),
    .ctrlWord   (ctrlWord),
    .vPriMask   (vPriMask)
  );

endmodule

// File: rtl/virq_cpu_port_chk.sv
module virq_cpu_port_chk
  import virq_cpu_port_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 guestRdEn,
  input logic                 guestWrEn,
  input logic [ADDR_W-1:0]    guestAddr,
  input logic [31:0]          guestRdData,
  input logic                 accessErr,
  input logic                 lrLoadEn,
  input logic [NUM_LR*32-1:0] lrState,
  input logic [31:0]          ctrlWord
);

  logic [NUM_LR-1:0] pendMask;
  always_comb
    for (int i = 0; i < NUM_LR; i++)
      pendMask[i] = (lrState[i*32+STATE_LSB +: 2] == ST_PEND);

  logic ackRd, eoiWr, soloErr;
  assign ackRd   = guestRdEn && !guestWrEn && (guestAddr == ADDR_W'(OFS_ACK));
  assign eoiWr   = guestWrEn && !guestRdEn && (guestAddr == ADDR_W'(OFS_EOI));
  assign soloErr = accessErr && !(guestRdEn && guestWrEn) && !lrLoadEn;

  assert_ack_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ackRd && (!ctrlWord[0] || pendMask == '0)) |-> guestRdData == NO_IRQ);

  assert_ack_fmt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ackRd && guestRdData != NO_IRQ) |-> guestRdData[31:13] == '0);

  assert_ack_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ackRd && !lrLoadEn && guestRdData != NO_IRQ)
      |=> $countones(pendMask) == $countones($past(pendMask)) - 1);

  assert_eoi_no_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoiWr && !lrLoadEn) |=> $countones(pendMask) <= $countones($past(pendMask)));

  assert_err_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soloErr |=> $stable(lrState) && $stable(ctrlWord));

  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accessErr && guestRdEn && !guestWrEn) |-> guestRdData == '0);

endmodule

bind virq_cpu_port virq_cpu_port_chk #(.NUM_LR(NUM_LR), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .guestRdEn  (guestRdEn),
  .guestWrEn  (guestWrEn),
  .guestAddr  (guestAddr),
  .guestRdData(guestRdData),
  .accessErr  (accessErr),
  .lrLoadEn   (lrLoadEn),
  .lrState    (lrState),
  .ctrlWord   (ctrlWord)
);

// File: tb/virq_cpu_port_tb.sv
module virq_cpu_port_tb;

  localparam logic [31:0] IDV = 32'h0000_5A3B;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        guestRdEn, guestWrEn;
  logic [2:0]  guestAddr;
  logic [31:0] guestWrData, guestRdData;
  logic        accessErr;
  logic        lrLoadEn;
  logic [1:0]  lrLoadIdx;
  logic [31:0] lrLoadData;
  logic [127:0] lrState;
  logic [4:0]  vPriMask;

  always #5 clk = ~clk;

  virq_cpu_port u_dut (
    .clk(clk), .rst_n(rst_n), .guestRdEn(guestRdEn), .guestWrEn(guestWrEn),
    .guestAddr(guestAddr), .guestWrData(guestWrData), .guestRdData(guestRdData),
    .accessErr(accessErr), .lrLoadEn(lrLoadEn), .lrLoadIdx(lrLoadIdx),
    .lrLoadData(lrLoadData), .lrState(lrState), .vPriMask(vPriMask)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mLr [4];
  logic [31:0] mCtrl;
  logic [4:0]  mPm;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkLr(int vid, int cpu, int prio, int st);
    return (32'(st) << 28) | (32'(prio & 31) << 23) | (32'(cpu & 7) << 10) | 32'(vid & 1023);
  endfunction

  // R1/R2 selection computed from the requirement text
  function automatic int pickIdx();
    int best = -1;
    if (!mCtrl[0]) return -1;
    for (int i = 0; i < 4; i++)
      if (mLr[i][29:28] == 2'd1 && (best < 0 || mLr[i][27:23] < mLr[best][27:23]))
        best = i;
    return best;
  endfunction

  task automatic checkLrs(string req);
    for (int i = 0; i < 4; i++) check(req, lrState[i*32 +: 32], mLr[i]);
    check(req, 32'(vPriMask), 32'(mPm));
  endtask

  task automatic doLoad(int idx, logic [31:0] d);
    @(negedge clk);
    lrLoadEn = 1'b1; lrLoadIdx = 2'(idx); lrLoadData = d;
    @(negedge clk);
    lrLoadEn = 1'b0;
    mLr[idx] = d;
  endtask

  task automatic doRead(int addr, string req);
    logic [31:0] exp;
    logic        expErr;
    int          k;
    @(negedge clk);
    guestRdEn = 1'b1; guestAddr = 3'(addr);
    #1;
    k = -1; expErr = 1'b0;
    case (addr)
      0: exp = mCtrl;
      2: begin
        k = pickIdx();
        exp = (k < 0) ? 32'd1023 : {19'd0, mLr[k][12:10], mLr[k][9:0]};
      end
      4: exp = IDV;
      default: begin exp = 32'd0; expErr = 1'b1; end
    endcase
    check(req, guestRdData, exp);
    check({req, " err"}, 32'(accessErr), 32'(expErr));
    @(negedge clk);
    guestRdEn = 1'b0;
    if (k >= 0) mLr[k][29:28] = 2'd2;
  endtask

  task automatic doWrite(int addr, logic [31:0] d, string req);
    logic expErr;
    @(negedge clk);
    guestWrEn = 1'b1; guestAddr = 3'(addr); guestWrData = d;
    #1;
    expErr = !(addr == 0 || addr == 1 || addr == 3);
    check({req, " err"}, 32'(accessErr), 32'(expErr));
    @(negedge clk);
    guestWrEn = 1'b0;
    case (addr)
      0: mCtrl = d;
      1: mPm = d[4:0];
      3: begin
        for (int i = 0; i < 4; i++)
          if (mLr[i][29:28] != 2'd0 && mLr[i][9:0] == d[9:0] && mLr[i][12:10] == d[12:10]) begin
            mLr[i][29:28] = 2'd0;
            break;
          end
      end
      default: ;
    endcase
  endtask

  logic done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; guestRdEn = 0; guestWrEn = 0; guestAddr = 0; guestWrData = 0;
    lrLoadEn = 0; lrLoadIdx = 0; lrLoadData = 0;
    for (int i = 0; i < 4; i++) mLr[i] = 0;
    mCtrl = 0; mPm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    @(negedge clk);
    checkLrs("R8 reset");
    doRead(0, "R6 ctrl reset");

    // R7 ID read, R6 control and mask
    doRead(4, "R7 id");
    doWrite(0, 32'hA5C3_0F01, "R6 ctrl write");
    doRead(0, "R6 ctrl readback");
    doWrite(1, 32'hFFFF_FFF6, "R6 mask write");
    @(negedge clk); checkLrs("R6 mask");

    // R1 with the interface disabled: nothing consumed
    doLoad(2, mkLr(77, 5, 4, 1));
    doWrite(0, 32'h0, "R1 disable");
    doRead(2, "R1 disabled ack");
    @(negedge clk); checkLrs("R1 disabled no change");
    doWrite(0, 32'h1, "R1 enable");

    // R9 unmapped accesses
    for (int a = 0; a < 8; a++) begin
      if (!(a == 0 || a == 2 || a == 4)) doRead(a, "R9 unmapped read");
      if (!(a == 0 || a == 1 || a == 3)) doWrite(a, 32'hFFFF_FFFF, "R9 unmapped write");
    end
    @(negedge clk); checkLrs("R9 no state change");
    doRead(0, "R9 ctrl intact");

    // R5 EOI with no match: wrong ID, then wrong CPU
    doWrite(3, (32'd5 << 10) | 32'd78, "R5 eoi wrong id");
    doWrite(3, (32'd4 << 10) | 32'd77, "R5 eoi wrong cpu");
    @(negedge clk); checkLrs("R5 no match");

    // sweep all 4^4 priority combinations (R2, R3, R4)
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 4; i++) begin
        int st;
        st = ((p % 5) == i) ? 2 : 1;
        doLoad(i, mkLr((p * 4 + i) % 1024, (i + p) % 8, (p >> (2 * i)) & 3, st));
      end
      for (int r = 0; r < 5; r++) doRead(2, "R2 ack select");
      @(negedge clk); checkLrs("R3 ack marks active");
      for (int i = 3; i >= 0; i--)
        doWrite(3, (32'((i + p) % 8) << 10) | 32'((p * 4 + i) % 1024), "R4 eoi");
      @(negedge clk); checkLrs("R4 eoi frees");
    end

    // R4 duplicate identity: lowest index freed first
    doLoad(0, mkLr(9, 1, 2, 2));
    doLoad(1, mkLr(9, 1, 2, 3));
    doWrite(3, (32'd1 << 10) | 32'd9, "R4 duplicate");
    @(negedge clk); checkLrs("R4 lowest index");

    // R10 load collides with acknowledge of the same entry
    doLoad(0, 32'h0);
    doLoad(1, 32'h0);
    doLoad(3, mkLr(300, 6, 1, 1));
    begin
      int k;
      k = pickIdx();
      @(negedge clk);
      guestRdEn = 1'b1; guestAddr = 3'd2;
      lrLoadEn = 1'b1; lrLoadIdx = 2'(k); lrLoadData = mkLr(301, 2, 7, 1);
      #1;
      check("R10 read old entry", guestRdData, {19'd0, mLr[k][12:10], mLr[k][9:0]});
      @(negedge clk);
      guestRdEn = 1'b0; lrLoadEn = 1'b0;
      mLr[k] = mkLr(301, 2, 7, 1);
      checkLrs("R10 load wins");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule